// File: doc/BRIEF.md
# TDMA Global Time Base

This block keeps one node's local view of network time in a time-division bus. Four nested counters run off the local clock: a microtick counter that counts clock cycles, a macrotick counter that moves each time the microtick counter wraps, a slot counter that moves each time the macrotick counter wraps, and a round counter that moves each time the slot counter wraps. The composite reading round:slot:macrotick is the node's global time, and the microtick count is its phase inside the current macrotick.

A clock synchronization unit outside this block measures the skew of each received frame and hands over a signed correction in microticks. The block applies it in one step by moving the microtick phase. When the move crosses the edge of a macrotick, the carry or borrow ripples up through slot and round. A correction as large as one full macrotick or larger is dropped. The block also raises a one-cycle strobe at each slot start, another at the start of each network cycle, and a transmit trigger at the start of the slot this node owns. A load input presets round and slot while the node joins a running network.

All sizes come from configuration inputs. Each one holds the last index of its counter, which is the count minus one. The configuration is expected to stay constant between resets.

Top module: `tdma_time_base`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, microtick_o, macrotick_o, slot_o and round_o are 0 and slot_start_o, cycle_start_o and tx_trigger_o are low.
- R2: With no correction and no load, microtick_o counts 0, 1, ... up to cfg_ut_last_i and then returns to 0. Each return to 0 advances the macrotick by exactly one.
- R3: macrotick_o wraps from cfg_mt_last_i to 0 and advances slot_o. slot_o wraps from cfg_slot_last_i to 0 and advances round_o. round_o wraps from cfg_round_last_i to 0.
- R4: slot_start_o is high for exactly the first cycle in which a new slot value shows after a forward advance or a load. It is high only while macrotick_o is 0.
- R5: cycle_start_o is high together with slot_start_o exactly when the new slot_o and round_o are both 0.
- R6: tx_trigger_o is high together with slot_start_o exactly when the new slot_o equals cfg_own_slot_i.
- R7: When corr_valid_i is high, the next microtick is microtick_o + 1 + corr_i, with corr_i read as two's complement. Without a correction it is microtick_o + 1.
- R8: If that sum is N or more, where N = cfg_ut_last_i + 1, the microtick becomes sum − N and one macrotick is carried up through slot and round. A carry into a new slot raises the slot strobes exactly once, even when the new microtick is not 0.
- R9: If that sum is below 0, the microtick becomes sum + N and one macrotick is borrowed. The borrow runs down through slot and round, so round 0 goes to cfg_round_last_i. A step back into an earlier slot raises no strobe.
- R10: A correction with |corr_i| ≥ N has no effect. The block makes the plain one-microtick advance.
- R11: When load_i is high, the next state is round load_round_i, slot load_slot_i, macrotick 0 and microtick 0, whatever corr_valid_i is. The slot strobes follow R4 to R6 for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one microtick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ut_last_i | input | MT_W | Microticks per macrotick minus 1 |
| cfg_mt_last_i | input | MAC_W | Macroticks per slot minus 1 |
| cfg_slot_last_i | input | SLOT_W | Slots per round minus 1 |
| cfg_round_last_i | input | ROUND_W | Rounds per cycle minus 1 |
| cfg_own_slot_i | input | SLOT_W | Slot in which this node transmits |
| corr_valid_i | input | 1 | Apply corr_i in this cycle |
| corr_i | input | CORR_W | Signed phase correction in microticks |
| load_i | input | 1 | Preset round and slot |
| load_round_i | input | ROUND_W | Round value used by a load |
| load_slot_i | input | SLOT_W | Slot value used by a load |
| microtick_o | output | MT_W | Phase within the current macrotick |
| macrotick_o | output | MAC_W | Macrotick within the current slot |
| slot_o | output | SLOT_W | Slot within the current round |
| round_o | output | ROUND_W | Round within the network cycle |
| slot_start_o | output | 1 | One-cycle strobe when a slot begins |
| cycle_start_o | output | 1 | One-cycle strobe when round 0, slot 0 begins |
| tx_trigger_o | output | 1 | One-cycle strobe when the owned slot begins |

## Verification
The hardest states to reach are the ones where a correction lands on a counter boundary. One case is a forward jump that skips microtick 0 of a new slot's first macrotick. The other is a negative correction at time zero that has to borrow all the way from round 0, slot 0 into the last round. The bench uses a very small network cycle. It loads round 0, slot 0 to pin down the phase, or free-runs until its own linear time model shows the last macrotick of a slot. It then issues the correction in the exact cycle needed. It compares every output each cycle against that model, which counts time as a single number modulo the cycle length.

// File: rtl/tdma_tb_pkg.sv
package tdma_tb_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BACK = 2'd2
  } step_e;

endpackage

// File: rtl/tdma_phase_adj.sv
module tdma_phase_adj
  import tdma_tb_pkg::*;
#(
  parameter int MT_W   = 8,
  parameter int CORR_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     corr_valid_i,
  input  logic signed [CORR_W-1:0] corr_i,
  input  logic [MT_W-1:0]          ut_last_i,
  output logic [MT_W-1:0]          ut_o,
  output step_e                    step_o
);

  localparam int SW = ((MT_W > CORR_W) ? MT_W : CORR_W) + 2;
  localparam logic signed [SW-1:0] OneS = SW'(1);

  logic [MT_W-1:0]        ut_q, ut_d;
  logic signed [SW-1:0]   n_s, ut_s, corr_s, mag_s, sum_s, wrap_s;
  logic                   apply;
  step_e                  step;

  always_comb begin
    n_s    = $signed({{(SW-MT_W){1'b0}}, ut_last_i}) + OneS;
    ut_s   = $signed({{(SW-MT_W){1'b0}}, ut_q});
    corr_s = {{(SW-CORR_W){corr_i[CORR_W-1]}}, corr_i};
    mag_s  = corr_s[SW-1] ? -corr_s : corr_s;
    // corrections of a macrotick or more are dropped
    apply  = corr_valid_i && (mag_s < n_s);
    sum_s  = ut_s + OneS + (apply ? corr_s : '0);
    wrap_s = sum_s;
    step   = STEP_HOLD;
    if (sum_s[SW-1]) begin
      wrap_s = sum_s + n_s;
      step   = STEP_BACK;
    end else if (sum_s >= n_s) begin
      wrap_s = sum_s - n_s;
      step   = STEP_FWD;
    end
    ut_d = wrap_s[MT_W-1:0];
    if (load_i) begin
      ut_d = '0;
      step = STEP_HOLD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ut_q <= '0;
    else         ut_q <= ut_d;
  end

  assign ut_o   = ut_q;
  assign step_o = step;

endmodule

// File: rtl/tdma_level_ctr.sv
module tdma_level_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] last_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         carry_o,
  output logic         borrow_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         carry, borrow;

  always_comb begin
    cnt_d  = cnt_q;
    carry  = 1'b0;
    borrow = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (inc_i) begin
      if (cnt_q >= last_i) begin
        cnt_d = '0;
        carry = 1'b1;
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end else if (dec_i) begin
      if (cnt_q == '0) begin
        cnt_d  = last_i;
        borrow = 1'b1;
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign carry_o   = carry;
  assign borrow_o  = borrow;

endmodule

// File: rtl/tdma_strobe_gen.sv
module tdma_strobe_gen #(
  parameter int SLOT_W  = 5,
  parameter int ROUND_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [SLOT_W-1:0]  slot_nxt_i,
  input  logic [ROUND_W-1:0] round_nxt_i,
  input  logic [SLOT_W-1:0]  own_slot_i,
  output logic               slot_start_o,
  output logic               cycle_start_o,
  output logic               tx_trigger_o
);

  logic enter;
  logic ss_q, cs_q, tx_q;

  // a new slot is entered by forward carry or by load, never by borrow
  assign enter = load_i | adv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_q <= 1'b0;
      cs_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      ss_q <= enter;
      cs_q <= enter && (slot_nxt_i == '0) && (round_nxt_i == '0);
      tx_q <= enter && (slot_nxt_i == own_slot_i);
    end
  end

  assign slot_start_o  = ss_q;
  assign cycle_start_o = cs_q;
  assign tx_trigger_o  = tx_q;

endmodule

// File: rtl/tdma_time_base.sv
module tdma_time_base
  import tdma_tb_pkg::*;
#(
  parameter int MT_W    = 8,
  parameter int MAC_W   = 8,
  parameter int SLOT_W  = 5,
  parameter int ROUND_W = 6,
  parameter int CORR_W  = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [MT_W-1:0]          cfg_ut_last_i,
  input  logic [MAC_W-1:0]         cfg_mt_last_i,
  input  logic [SLOT_W-1:0]        cfg_slot_last_i,
  input  logic [ROUND_W-1:0]       cfg_round_last_i,
  input  logic [SLOT_W-1:0]        cfg_own_slot_i,
  input  logic                     corr_valid_i,
  input  logic signed [CORR_W-1:0] corr_i,
  input  logic                     load_i,
  input  logic [ROUND_W-1:0]       load_round_i,
  input  logic [SLOT_W-1:0]        load_slot_i,
  output logic [MT_W-1:0]          microtick_o,
  output logic [MAC_W-1:0]         macrotick_o,
  output logic [SLOT_W-1:0]        slot_o,
  output logic [ROUND_W-1:0]       round_o,
  output logic                     slot_start_o,
  output logic                     cycle_start_o,
  output logic                     tx_trigger_o
);

  step_e               ut_step;
  logic                mt_inc, mt_dec;
  logic                mt_carry, mt_borrow;
  logic                sl_carry, sl_borrow;
  logic                rd_carry, rd_borrow;
  logic [MAC_W-1:0]    mt_nxt;
  logic [SLOT_W-1:0]   sl_nxt;
  logic [ROUND_W-1:0]  rd_nxt;

  tdma_phase_adj #(
    .MT_W   (MT_W),
    .CORR_W (CORR_W)
  ) u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .corr_valid_i (corr_valid_i),
    .corr_i       (corr_i),
    .ut_last_i    (cfg_ut_last_i),
    .ut_o         (microtick_o),
    .step_o       (ut_step)
  );

  assign mt_inc = (ut_step == STEP_FWD);
  assign mt_dec = (ut_step == STEP_BACK);

  tdma_level_ctr #(.W(MAC_W)) u_mt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i ('0),
    .last_i     (cfg_mt_last_i),
    .inc_i      (mt_inc),
    .dec_i      (mt_dec),
    .cnt_o      (macrotick_o),
    .cnt_nxt_o  (mt_nxt),
    .carry_o    (mt_carry),
    .borrow_o   (mt_borrow)
  );

  tdma_level_ctr #(.W(SLOT_W)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_slot_i),
    .last_i     (cfg_slot_last_i),
    .inc_i      (mt_carry),
    .dec_i      (mt_borrow),
    .cnt_o      (slot_o),
    .cnt_nxt_o  (sl_nxt),
    .carry_o    (sl_carry),
    .borrow_o   (sl_borrow)
  );

  tdma_level_ctr #(.W(ROUND_W)) u_round (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_round_i),
    .last_i     (cfg_round_last_i),
    .inc_i      (sl_carry),
    .dec_i      (sl_borrow),
    .cnt_o      (round_o),
    .cnt_nxt_o  (rd_nxt),
    .carry_o    (rd_carry),
    .borrow_o   (rd_borrow)
  );

  tdma_strobe_gen #(
    .SLOT_W  (SLOT_W),
    .ROUND_W (ROUND_W)
  ) u_strobe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load_i),
    .adv_i         (mt_carry),
    .slot_nxt_i    (sl_nxt),
    .round_nxt_i   (rd_nxt),
    .own_slot_i    (cfg_own_slot_i),
    .slot_start_o  (slot_start_o),
    .cycle_start_o (cycle_start_o),
    .tx_trigger_o  (tx_trigger_o)
  );

  // the round level's wrap flags and the macrotick next value have no consumer
  logic unused_ok;
  assign unused_ok = ^{rd_carry, rd_borrow, mt_nxt};

endmodule

// File: rtl/tdma_time_base_chk.sv
module tdma_time_base_chk #(
  parameter int MT_W    = 8,
  parameter int MAC_W   = 8,
  parameter int SLOT_W  = 5,
  parameter int ROUND_W = 6,
  parameter int CORR_W  = 9
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [MT_W-1:0]          cfg_ut_last_i,
  input logic [MAC_W-1:0]         cfg_mt_last_i,
  input logic [SLOT_W-1:0]        cfg_slot_last_i,
  input logic [ROUND_W-1:0]       cfg_round_last_i,
  input logic [SLOT_W-1:0]        cfg_own_slot_i,
  input logic                     corr_valid_i,
  input logic signed [CORR_W-1:0] corr_i,
  input logic                     load_i,
  input logic [ROUND_W-1:0]       load_round_i,
  input logic [SLOT_W-1:0]        load_slot_i,
  input logic [MT_W-1:0]          microtick_o,
  input logic [MAC_W-1:0]         macrotick_o,
  input logic [SLOT_W-1:0]        slot_o,
  input logic [ROUND_W-1:0]       round_o,
  input logic                     slot_start_o,
  input logic                     cycle_start_o,
  input logic                     tx_trigger_o
);

  localparam int XW = ((MT_W > CORR_W) ? MT_W : CORR_W) + 2;

  logic signed [XW-1:0] c_x, n_x, m_x;
  logic                 big_corr;

  assign c_x      = {{(XW-CORR_W){corr_i[CORR_W-1]}}, corr_i};
  assign n_x      = $signed({{(XW-MT_W){1'b0}}, cfg_ut_last_i}) + XW'(1);
  assign m_x      = c_x[XW-1] ? -c_x : c_x;
  assign big_corr = m_x >= n_x;

  assert_ut_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    microtick_o <= cfg_ut_last_i);

  assert_ut_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !corr_valid_i) |=>
      microtick_o == (($past(microtick_o) == $past(cfg_ut_last_i)) ? '0
                      : $past(microtick_o) + MT_W'(1)));

  assert_ignore_big_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && corr_valid_i && big_corr) |=>
      microtick_o == (($past(microtick_o) == $past(cfg_ut_last_i)) ? '0
                      : $past(microtick_o) + MT_W'(1)));

  assert_slot_start_mt0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |-> (macrotick_o == '0));

  assert_cycle_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> (slot_start_o && slot_o == '0 && round_o == '0));

  assert_tx_trigger_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_trigger_o |-> (slot_start_o && slot_o == cfg_own_slot_i));

  assert_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (slot_o == $past(load_slot_i) && round_o == $past(load_round_i) &&
                macrotick_o == '0 && microtick_o == '0 && slot_start_o));

  logic unused_ok;
  assign unused_ok = ^{cfg_mt_last_i, cfg_slot_last_i, cfg_round_last_i};

endmodule

bind tdma_time_base tdma_time_base_chk #(
  .MT_W    (MT_W),
  .MAC_W   (MAC_W),
  .SLOT_W  (SLOT_W),
  .ROUND_W (ROUND_W),
  .CORR_W  (CORR_W)
) u_chk (.*);

// File: tb/tdma_time_base_tb.sv
`timescale 1ns/1ps
module tdma_time_base_tb;

  localparam int UTL = 4, MTL = 2, SLL = 3, RDL = 1, OWN = 2;
  localparam int N = UTL + 1, M = MTL + 1, S = SLL + 1, R = RDL + 1;
  localparam int TOTAL = N * M * S * R;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              corr_v = 1'b0;
  logic signed [8:0] corr = '0;
  logic              ld = 1'b0;
  logic [5:0]        ld_round = '0;
  logic [4:0]        ld_slot = '0;
  logic [7:0]        ut;
  logic [7:0]        mt;
  logic [4:0]        slot;
  logic [5:0]        round;
  logic              ss, cs, tx;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // linear time model
  int t_m = 0;
  bit ss_m = 0, cs_m = 0, tx_m = 0;

  always #10 clk = ~clk;

  tdma_time_base u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .cfg_ut_last_i    (8'(UTL)),
    .cfg_mt_last_i    (8'(MTL)),
    .cfg_slot_last_i  (5'(SLL)),
    .cfg_round_last_i (6'(RDL)),
    .cfg_own_slot_i   (5'(OWN)),
    .corr_valid_i     (corr_v),
    .corr_i           (corr),
    .load_i           (ld),
    .load_round_i     (ld_round),
    .load_slot_i      (ld_slot),
    .microtick_o      (ut),
    .macrotick_o      (mt),
    .slot_o           (slot),
    .round_o          (round),
    .slot_start_o     (ss),
    .cycle_start_o    (cs),
    .tx_trigger_o     (tx)
  );

  function automatic int m_ut();    return t_m % N;               endfunction
  function automatic int m_mt();    return (t_m / N) % M;         endfunction
  function automatic int m_slot();  return (t_m / (N * M)) % S;   endfunction
  function automatic int m_round(); return t_m / (N * M * S);     endfunction

  task automatic check_state(input string req);
    checks++;
    if (ut != 8'(m_ut()) || mt != 8'(m_mt()) || slot != 5'(m_slot()) ||
        round != 6'(m_round()) || ss != ss_m || cs != cs_m || tx != tx_m) begin
      failures++;
      $display("FAIL %s: got ut=%0d mt=%0d slot=%0d round=%0d ss=%0b cs=%0b tx=%0b exp ut=%0d mt=%0d slot=%0d round=%0d ss=%0b cs=%0b tx=%0b",
               req, ut, mt, slot, round, ss, cs, tx,
               m_ut(), m_mt(), m_slot(), m_round(), ss_m, cs_m, tx_m);
    end
  endtask

  task automatic model_step(input bit v, input int c, input bit l, input int lr, input int ls);
    int old_idx, new_idx, d;
    if (l) begin
      t_m  = ((lr * S + ls) * M) * N;
      ss_m = 1;
      cs_m = (lr == 0 && ls == 0);
      tx_m = (ls == OWN);
    end else begin
      old_idx = t_m / (N * M);
      d = 1 + ((v && c < N && c > -N) ? c : 0);
      t_m = (t_m + d + TOTAL) % TOTAL;
      new_idx = t_m / (N * M);
      ss_m = (new_idx != old_idx) && (new_idx == (old_idx + 1) % (S * R));
      cs_m = ss_m && (new_idx == 0);
      tx_m = ss_m && (m_slot() == OWN);
    end
  endtask

  // called at a negative edge; checks after the next rising edge
  task automatic tick(input bit v, input int c, input bit l, input int lr, input int ls,
                      input string req);
    corr_v   = v;
    corr     = 9'(c);
    ld       = l;
    ld_round = 6'(lr);
    ld_slot  = 5'(ls);
    @(posedge clk);
    model_step(v, c, l, lr, ls);
    @(negedge clk);
    corr_v = 1'b0;
    corr   = '0;
    ld     = 1'b0;
    check_state(req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_state("R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_state("R1 after release");
  endtask

  task automatic t_free_run();
    int ss_cnt = 0, tx_cnt = 0;
    for (int i = 0; i < TOTAL + 10; i++) begin
      tick(0, 0, 0, 0, 0, "R2/R3/R4/R5/R6 free run");
      if (ss) ss_cnt++;
      if (tx) tx_cnt++;
    end
    checks++;
    if (ss_cnt != S * R || tx_cnt != R) begin
      failures++;
      $display("FAIL R4/R6 strobe count: got ss=%0d tx=%0d exp ss=%0d tx=%0d",
               ss_cnt, tx_cnt, S * R, R);
    end
  endtask

  task automatic t_corr_fwd();
    // plain corrections inside a macrotick
    tick(1, 2, 0, 0, 0, "R7 small positive");
    tick(1, -1, 0, 0, 0, "R7 minus one holds");
    // jump over microtick 0 into the next slot
    while (!(m_ut() == 2 && m_mt() == MTL)) tick(0, 0, 0, 0, 0, "R2 align");
    tick(1, 4, 0, 0, 0, "R8 carry into new slot");
    checks++;
    if (!(ss && ut == 8'd2 && mt == 8'd0)) begin
      failures++;
      $display("FAIL R8 skip-zero strobe: got ss=%0b ut=%0d mt=%0d exp ss=1 ut=2 mt=0",
               ss, ut, mt);
    end
    tick(0, 0, 0, 0, 0, "R8 single strobe");
  endtask

  task automatic t_corr_back();
    tick(0, 0, 1, 0, 0, "R11 load origin");
    tick(1, -3, 0, 0, 0, "R9 borrow through round");
    checks++;
    if (!(round == 6'(RDL) && slot == 5'(SLL) && mt == 8'(MTL) && ut == 8'd3 && !ss)) begin
      failures++;
      $display("FAIL R9 full borrow: got r=%0d s=%0d mt=%0d ut=%0d ss=%0b exp r=%0d s=%0d mt=%0d ut=3 ss=0",
               round, slot, mt, ut, ss, RDL, SLL, MTL);
    end
    // stepping forward again re-enters round 0 slot 0
    while (t_m != TOTAL - 1) tick(0, 0, 0, 0, 0, "R3 run to wrap");
    tick(0, 0, 0, 0, 0, "R5 cycle start after wrap");
  endtask

  task automatic t_ignore();
    tick(1, N, 0, 0, 0, "R10 plus N ignored");
    tick(1, -N, 0, 0, 0, "R10 minus N ignored");
    tick(1, 100, 0, 0, 0, "R10 large ignored");
    tick(1, -(N - 1), 0, 0, 0, "R7 largest negative applied");
  endtask

  task automatic t_load();
    tick(1, 3, 1, 1, OWN, "R11 load beats correction");
    checks++;
    if (!(tx && ss && !cs)) begin
      failures++;
      $display("FAIL R11 load strobes: got ss=%0b cs=%0b tx=%0b exp ss=1 cs=0 tx=1", ss, cs, tx);
    end
    tick(0, 0, 0, 0, 0, "R4 strobe drops");
    tick(0, 0, 1, 0, 0, "R11 R5 load origin");
    tick(0, 0, 1, 1, SLL, "R11 load last slot");
    for (int i = 0; i < N * M + 2; i++) tick(0, 0, 0, 0, 0, "R3 wrap to round 0");
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_corr_fwd();
    t_corr_back();
    t_ignore();
    t_load();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule